// File: doc/BRIEF.md
# Subroutine call/return stack sequencer

This block carries out the stack half of subroutine linkage for a small 8-bit core whose program counter counts 16-bit words. When `start` is raised with an operation code, it latches the operands and the stack pointer. A call stores the return address into data memory. A return reads a saved address back. The block then delivers the new program counter, the new stack pointer and the status byte, and reports how many cycles the instruction took.

A single parameter sets the program counter width. A width of 16 bits saves 2 bytes per call. Any wider setting (22 bits by default) saves 3 bytes and adds one cycle to every operation. Data memory is reached through a single byte-wide port with a combinational read, and the block makes at most one access in any cycle. Decode, the register file and the memory array itself sit outside the block.

Top module: `call_ret_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_we`, `pc_out` and `sp_out` are all 0.
- R2: A call (op 0, 1 or 2) writes the return address with its least significant byte at the latched SP, the next byte at SP-1 and, when wide, bits 21:16 (upper two bits zero) at SP-2. `sp_out` becomes SP-2 when the counter is 16 bits wide and SP-3 when it is wider.
- R3: A return (op 3 or 4) reads SP+1 first, as the most significant byte, and the least significant byte last, at SP+2 or SP+3. `pc_out` is those bytes joined and truncated to PC_W bits. `sp_out` becomes SP+2 or SP+3.
- R4: The saved return address is PC+2 for the long call (op 0) and PC+1 for the indirect call (op 1) and the relative call (op 2), modulo 2^PC_W.
- R5: The call target is the far target input for op 0, the zero-extended 16-bit pointer for op 1, and PC+1 plus the sign-extended 12-bit offset, modulo 2^PC_W, for op 2.
- R6: `busy` is high for exactly N cycles after the start edge, and `cycles_out` equals N. For a 16-bit counter N is 4 for op 0, 3 for op 1, 3 for op 2, 4 for op 3 and 4 for op 4. A wider counter adds 1 to each.
- R7: `done` is a single-cycle pulse in the cycle right after `busy` falls, with `pc_out`, `sp_out`, `sreg_out` and `cycles_out` valid in that cycle. `mem_we` is high only while a call is busy.
- R8: Op 4 returns `sreg_out` as the latched status with bit 7 set. Every other operation returns the latched status unchanged.
- R9: `start` is ignored while `busy` is high and whenever the op code is 5, 6 or 7. An ignored `start` produces no busy cycle, no done pulse and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | 0 long call, 1 indirect call, 2 relative call, 3 return, 4 return from interrupt |
| pc_in | input | PC_W | Word address of the current instruction |
| far_tgt | input | PC_W | Target taken from the second instruction word |
| ptr_in | input | 16 | Pointer register pair value |
| rel_off | input | 12 | Signed word offset for the relative call |
| sp_in | input | 16 | Stack pointer before the operation |
| sreg_in | input | 8 | Status byte before the operation |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte, combinational from mem_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | PC_W | New program counter |
| sp_out | output | 16 | New stack pointer |
| sreg_out | output | 8 | New status byte |
| cycles_out | output | 3 | Cycle count of the finished operation |

## Verification
Two copies of the block run side by side on the same stimulus, one at 16 bits and one at 22 bits. This separates the 2-byte and 3-byte push and pop, the stack pointer step and the extra cycle. Directed calls start from the top of the address space and use offsets of both signs, which exposes wrap handling that a wrong width or a missing sign extension would get wrong. Returns read random bytes, including high bytes with bits 7:6 set, which shows whether truncation and byte order are right. A second start issued in the middle of an operation, and illegal op codes, each show whether a request is wrongly accepted.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [2:0] {
    OP_LCALL = 3'd0,
    OP_ICALL = 3'd1,
    OP_RCALL = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4
  } crs_op_e;

  function automatic logic op_known(logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_call(crs_op_e o);
    return (o == OP_LCALL) || (o == OP_ICALL) || (o == OP_RCALL);
  endfunction

  // base cost for a two-byte return address, plus one when three bytes move
  function automatic logic [2:0] op_cycles(crs_op_e o, logic wide);
    logic [2:0] base;
    case (o)
      OP_ICALL, OP_RCALL: base = 3'd3;
      default:            base = 3'd4;
    endcase
    return base + {2'b00, wide};
  endfunction
endpackage

// File: rtl/crs_target.sv
module crs_target
  import crs_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  crs_op_e           op,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   far_tgt,
  input  logic [15:0]       ptr,
  input  logic [11:0]       rel_off,
  output logic [PC_W-1:0]   ret_addr,
  output logic [PC_W-1:0]   call_tgt
);
  function automatic logic [PC_W-1:0] next_pc(logic [PC_W-1:0] p, logic two_words);
    return p + (two_words ? PC_W'(2) : PC_W'(1));
  endfunction

  function automatic logic [PC_W-1:0] rel_pc(logic [PC_W-1:0] p, logic [11:0] o);
    return p + PC_W'(1) + {{(PC_W-12){o[11]}}, o};
  endfunction

  assign ret_addr = next_pc(pc, op == OP_LCALL);

  always_comb begin
    case (op)
      OP_LCALL: call_tgt = far_tgt;
      OP_ICALL: call_tgt = PC_W'(ptr);
      default:  call_tgt = rel_pc(pc, rel_off);
    endcase
  end
endmodule

// File: rtl/crs_seq.sv
module crs_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [2:0] len,
  output logic       busy,
  output logic [2:0] step,
  output logic       last
);
  assign last = busy && (step == len - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= 3'd0;
    end else if (launch) begin
      busy <= 1'b1;
      step <= 3'd0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      step <= step + 3'd1;
    end
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step < len));

  // R9
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/crs_lane.sv
module crs_lane #(
  parameter int NB = 3
) (
  input  logic        busy,
  input  logic        is_call,
  input  logic [2:0]  step,
  input  logic [15:0] sp_base,
  input  logic [23:0] ret_word,
  output logic [15:0] addr,
  output logic        we,
  output logic [7:0]  wdata,
  output logic        rd_en
);
  logic active;

  assign active = busy && (step < 3'(NB));
  // push walks downward from SP, pop walks upward from SP+1
  assign addr   = is_call ? (sp_base - 16'(step)) : (sp_base + 16'(step) + 16'd1);
  assign wdata  = 8'(ret_word >> {step, 3'b000});
  assign we     = active && is_call;
  assign rd_en  = active && !is_call;
endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
  import crs_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] pc_in,
  input  logic [PC_W-1:0] far_tgt,
  input  logic [15:0]     ptr_in,
  input  logic [11:0]     rel_off,
  input  logic [15:0]     sp_in,
  input  logic [7:0]      sreg_in,
  output logic [15:0]     mem_addr,
  output logic            mem_we,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PC_W-1:0] pc_out,
  output logic [15:0]     sp_out,
  output logic [7:0]      sreg_out,
  output logic [2:0]      cycles_out
);
  localparam int   NB   = (PC_W > 16) ? 3 : 2;
  localparam logic WIDE = (PC_W > 16);

  crs_op_e         op_in, op_q;
  logic            call_q, launch, last, rd_en;
  logic [2:0]      step, len_q;
  logic [15:0]     sp_q;
  logic [23:0]     ret_q;
  logic [PC_W-1:0] tgt_q, pop_q, ret_addr, call_tgt;
  logic [7:0]      sreg_q;

  assign op_in  = crs_op_e'(op);
  assign launch = start && !busy && op_known(op);

  crs_target #(.PC_W(PC_W)) u_target (
    .op(op_in), .pc(pc_in), .far_tgt(far_tgt), .ptr(ptr_in),
    .rel_off(rel_off), .ret_addr(ret_addr), .call_tgt(call_tgt)
  );

  crs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .len(len_q),
    .busy(busy), .step(step), .last(last)
  );

  crs_lane #(.NB(NB)) u_lane (
    .busy(busy), .is_call(call_q), .step(step), .sp_base(sp_q),
    .ret_word(ret_q), .addr(mem_addr), .we(mem_we), .wdata(mem_wdata),
    .rd_en(rd_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_LCALL;
      call_q     <= 1'b0;
      sp_q       <= '0;
      ret_q      <= '0;
      tgt_q      <= '0;
      pop_q      <= '0;
      sreg_q     <= '0;
      len_q      <= 3'd1;
      done       <= 1'b0;
      pc_out     <= '0;
      sp_out     <= '0;
      sreg_out   <= '0;
      cycles_out <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        op_q   <= op_in;
        call_q <= op_is_call(op_in);
        sp_q   <= sp_in;
        ret_q  <= 24'(ret_addr);
        tgt_q  <= call_tgt;
        sreg_q <= sreg_in;
        len_q  <= op_cycles(op_in, WIDE);
        pop_q  <= '0;
      end else if (rd_en) begin
        // most significant byte arrives first; excess top bits fall off
        pop_q <= PC_W'({pop_q, mem_rdata});
      end
      if (last) begin
        done       <= 1'b1;
        pc_out     <= call_q ? tgt_q : pop_q;
        sp_out     <= call_q ? (sp_q - 16'(NB)) : (sp_q + 16'(NB));
        sreg_out   <= (op_q == OP_RETI) ? (sreg_q | 8'h80) : sreg_q;
        cycles_out <= len_q;
      end
    end
  end

  // R7
  we_in_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && call_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && call_q) |-> ((sp_out + 16'(NB)) == sp_q));

  // R3
  ret_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !call_q) |-> ((sp_out - 16'(NB)) == sp_q));

  // R8
  reti_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RETI) |-> sreg_out[7]);
endmodule

// File: tb/call_ret_seq_bench.sv
module call_ret_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [21:0] pc = '0, far = '0;
  logic [15:0] ptr = '0, sp = '0;
  logic [11:0] off = '0;
  logic [7:0]  sreg = '0;

  logic [15:0] w_addr, n_addr, w_sp, n_sp;
  logic        w_we, n_we, w_busy, n_busy, w_done, n_done;
  logic [7:0]  w_wd, n_wd, w_rd, n_rd, w_sr, n_sr;
  logic [21:0] w_pc;
  logic [15:0] n_pc;
  logic [2:0]  w_cyc, n_cyc;
  logic [7:0]  mem_w [256];
  logic [7:0]  mem_n [256];

  assign w_rd = mem_w[w_addr[7:0]];
  assign n_rd = mem_n[n_addr[7:0]];
  always @(posedge clk) begin
    if (w_we) mem_w[w_addr[7:0]] <= w_wd;
    if (n_we) mem_n[n_addr[7:0]] <= n_wd;
  end

  call_ret_seq #(.PC_W(22)) u_call_ret_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc),
    .far_tgt(far), .ptr_in(ptr), .rel_off(off), .sp_in(sp), .sreg_in(sreg),
    .mem_addr(w_addr), .mem_we(w_we), .mem_wdata(w_wd), .mem_rdata(w_rd),
    .busy(w_busy), .done(w_done), .pc_out(w_pc), .sp_out(w_sp),
    .sreg_out(w_sr), .cycles_out(w_cyc)
  );

  call_ret_seq #(.PC_W(16)) u_call_ret_seq_narrow (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc[15:0]),
    .far_tgt(far[15:0]), .ptr_in(ptr), .rel_off(off), .sp_in(sp), .sreg_in(sreg),
    .mem_addr(n_addr), .mem_we(n_we), .mem_wdata(n_wd), .mem_rdata(n_rd),
    .busy(n_busy), .done(n_done), .pc_out(n_pc), .sp_out(n_sp),
    .sreg_out(n_sr), .cycles_out(n_cyc)
  );

  int checks = 0, failures = 0;
  int bcnt [2], dcnt [2];
  logic [31:0] cpc [2], csp [2], csr [2], ccyc [2];
  bit seq_ok [2];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ex_mask(int w);
    return (32'd1 << w) - 32'd1;
  endfunction

  function automatic logic [31:0] ex_ret(logic [2:0] o, logic [31:0] p, int w);
    return ((p & ex_mask(w)) + ((o == 3'd0) ? 32'd2 : 32'd1)) & ex_mask(w);
  endfunction

  function automatic logic [31:0] ex_tgt(logic [2:0] o, logic [31:0] p, logic [31:0] f,
                                         logic [15:0] z, logic [11:0] r, int w);
    logic [31:0] sx;
    sx = {{20{r[11]}}, r};
    case (o)
      3'd0:    return f & ex_mask(w);
      3'd1:    return {16'h0, z};
      default: return ((p & ex_mask(w)) + 32'd1 + sx) & ex_mask(w);
    endcase
  endfunction

  function automatic logic [31:0] ex_cyc(logic [2:0] o, int w);
    logic [31:0] b;
    b = (o == 3'd1 || o == 3'd2) ? 32'd3 : 32'd4;
    return b + ((w > 16) ? 32'd1 : 32'd0);
  endfunction

  function automatic logic [7:0] rd_mem(int x, logic [15:0] a);
    return (x == 0) ? mem_w[a[7:0]] : mem_n[a[7:0]];
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [21:0] p, input logic [21:0] f,
                        input logic [15:0] z, input logic [11:0] r, input logic [15:0] s,
                        input logic [7:0] sr, input bit mid);
    logic [7:0]  b [3];
    logic [15:0] a;
    bit pb [2];
    for (int k = 0; k < 3; k++) begin
      b[k] = 8'($urandom);
      if (o >= 3'd3) a = s + 16'(k) + 16'd1;
      else           a = s - 16'(k);
      mem_w[a[7:0]] = (o >= 3'd3) ? b[k] : 8'h00;
      mem_n[a[7:0]] = (o >= 3'd3) ? b[k] : 8'h00;
    end
    for (int x = 0; x < 2; x++) begin
      bcnt[x] = 0; dcnt[x] = 0; seq_ok[x] = 1'b0; pb[x] = 1'b0;
    end
    @(negedge clk);
    op = o; pc = p; far = f; ptr = z; off = r; sp = s; sreg = sr; start = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) begin
        start = mid;
        if (mid) begin op = 3'd3; pc = 22'h155555; sp = s + 16'h10; end
      end
      if (i == 1) begin start = 1'b0; op = o; pc = p; sp = s; end
      if (w_busy) bcnt[0]++;
      if (w_done) begin
        dcnt[0]++; seq_ok[0] = pb[0];
        cpc[0] = 32'(w_pc); csp[0] = 32'(w_sp); csr[0] = 32'(w_sr); ccyc[0] = 32'(w_cyc);
      end
      pb[0] = w_busy;
      if (n_busy) bcnt[1]++;
      if (n_done) begin
        dcnt[1]++; seq_ok[1] = pb[1];
        cpc[1] = 32'(n_pc); csp[1] = 32'(n_sp); csr[1] = 32'(n_sr); ccyc[1] = 32'(n_cyc);
      end
      pb[1] = n_busy;
    end
    for (int x = 0; x < 2; x++) begin
      int w, nb;
      logic [31:0] ra, ep;
      w  = (x == 0) ? 22 : 16;
      nb = (x == 0) ? 3 : 2;
      chk("R6", "busy cycles", 32'(bcnt[x]), ex_cyc(o, w));
      chk("R6", "cycles_out", ccyc[x], ex_cyc(o, w));
      chk("R7", "one done right after busy", {31'd0, (dcnt[x] == 1) && seq_ok[x]}, 32'd1);
      if (mid) chk("R9", "start while busy ignored", 32'(dcnt[x]), 32'd1);
      if (o <= 3'd2) begin
        ra = {24'h0, rd_mem(x, s)} | ({24'h0, rd_mem(x, s - 16'd1)} << 8);
        if (nb == 3) ra = ra | ({24'h0, rd_mem(x, s - 16'd2)} << 16);
        chk("R2", "low byte at SP", {24'h0, rd_mem(x, s)}, ex_ret(o, p, w) & 32'hFF);
        chk("R4", "saved return address", ra, ex_ret(o, p, w));
        chk("R2", "sp after push", csp[x], 32'(s - 16'(nb)));
        chk("R5", "call target", cpc[x], ex_tgt(o, p, f, z, r, w));
        chk("R8", "status after call", csr[x], {24'h0, sr});
      end else begin
        ep = (nb == 3) ? ({8'h0, b[0], b[1], b[2]} & 32'h3FFFFF) : {16'h0, b[0], b[1]};
        chk("R3", "popped pc", cpc[x], ep);
        chk("R3", "sp after pop", csp[x], 32'(s + 16'(nb)));
        chk("R8", "status after return", csr[x],
            {24'h0, (o == 3'd4) ? (sr | 8'h80) : sr});
      end
    end
  endtask

  task automatic bad_op(input logic [2:0] o, input logic [15:0] s);
    int seen;
    seen = 0;
    mem_w[s[7:0]] = 8'h3C;
    mem_n[s[7:0]] = 8'h3C;
    @(negedge clk);
    op = o; sp = s; pc = 22'h000100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (w_busy || w_done || n_busy || n_done) seen++;
      @(negedge clk);
    end
    chk("R9", "illegal op leaves block idle", 32'(seen), 32'd0);
    chk("R9", "illegal op writes nothing", {24'h0, mem_w[s[7:0]]}, 32'h3C);
    chk("R9", "illegal op writes nothing narrow", {24'h0, mem_n[s[7:0]]}, 32'h3C);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "reset busy/done/we", {29'd0, w_busy, w_done, w_we}, 32'd0);
    chk("R1", "reset pc/sp", {10'd0, w_pc} | {16'd0, w_sp}, 32'd0);
    chk("R1", "reset narrow", {29'd0, n_busy, n_done, n_we} | {16'd0, n_pc} | {16'd0, n_sp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after release", {29'd0, w_busy, w_done, w_we} | {16'd0, w_sp}, 32'd0);

    run_op(3'd0, 22'h3FFFFF, 22'h2ABCDE, 16'h0, 12'h0, 16'h0080, 8'h12, 1'b0);
    run_op(3'd1, 22'h001234, 22'h0, 16'hBEEF, 12'h0, 16'h0060, 8'h00, 1'b0);
    run_op(3'd2, 22'h3FFFFF, 22'h0, 16'h0, 12'h004, 16'h0070, 8'h55, 1'b0);
    run_op(3'd2, 22'h000000, 22'h0, 16'h0, 12'h800, 16'h0090, 8'h00, 1'b0);
    run_op(3'd2, 22'h010010, 22'h0, 16'h0, 12'h7FF, 16'h00A0, 8'h00, 1'b0);
    run_op(3'd3, 22'h0, 22'h0, 16'h0, 12'h0, 16'h0090, 8'h01, 1'b0);
    run_op(3'd4, 22'h0, 22'h0, 16'h0, 12'h0, 16'h00C0, 8'h01, 1'b0);
    run_op(3'd4, 22'h0, 22'h0, 16'h0, 12'h0, 16'h0040, 8'h80, 1'b0);
    run_op(3'd0, 22'h000200, 22'h001000, 16'h0, 12'h0, 16'h0050, 8'h00, 1'b1);
    run_op(3'd3, 22'h0, 22'h0, 16'h0, 12'h0, 16'h0030, 8'h7F, 1'b1);
    bad_op(3'd5, 16'h0088);
    bad_op(3'd6, 16'h0089);
    bad_op(3'd7, 16'h008A);

    for (int n = 0; n < 60; n++) begin
      run_op(3'($urandom % 5), 22'($urandom), 22'($urandom), 16'($urandom),
             12'($urandom), 16'h0020 + 16'($urandom % 192), 8'($urandom),
             ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule